// File: doc/BRIEF.md
# Codec Command and Response Ring Engine

This block sits on the controller side of a codec link and moves traffic through two circular buffers, each 256 entries deep. The outbound ring holds 32-bit codec commands. Software fills the entries and then advances a write pointer. The hardware drains the ring one command at a time onto a valid/ready command port that feeds the serial-link stub. The inbound ring holds 64-bit responses. Each response arrives on a valid/ready port and is written into local storage. The low word of an entry is the response itself. The high word is the extended word, and its bit 4 marks an unsolicited event.

Both rings are local dual-port memories. Software writes the command memory through a dedicated write port and reads the response memory through a dedicated read port. A small register port holds the ring pointers, the enables, the response interrupt threshold and the status bits. The block raises an interrupt after a programmed number of stored responses, and also when a response has to be dropped because the ring is full. A pending counter tracks how many sent commands still await a solicited reply.

Back-pressure rules:
- `cmd_valid` stays high with `cmd_data` held stable until the cycle in which `cmd_ready` is seen high.
- `rsp_in_ready` depends only on the response enable and on a same-cycle pointer clear. A full ring does not lower it: the response is accepted and then discarded.

Top module: `codec_cmd_rsp_rings`

## Requirements
- R1: After reset, all pointers, control fields, the threshold, the status bits and the pending count are zero. `cmd_valid`, `rsp_in_ready` and `irq` are low.
- R2: While command enable (bit 1 at address 2) is set and the hardware read pointer differs from the write pointer, the entry at read pointer + 1 (mod 256) is offered on `cmd_data`. Each handshake advances the read pointer by one. A following entry is offered in the very next cycle. Sending stops when the pointers are equal.
- R3: An offered command stays valid and unchanged until accepted, even if the command enable is cleared meanwhile. After that command is accepted, no further command is offered and the read pointer holds.
- R4: A register write to address 1 with bit 15 set clears the command read pointer to zero when no command is in flight. The write has no effect while a command is in flight, and it also has no effect when bit 15 is clear. Reads of address 1 return the read pointer.
- R5: With response enable (bit 1 at address 6) set, `rsp_in_ready` is high. An accepted response is stored at response write pointer + 1, and the pointer then advances. Entry bits 31:0 hold the response word and bits 63:32 hold the extended word.
- R6: If the ring is full when a response is accepted, the response is dropped, the write pointer holds, and overrun status (bit 2 at address 7) sets. The ring is full when write pointer + 1 equals the software read pointer at address 4.
- R7: Each stored response increments an entry counter. When the counter reaches the threshold at address 5, response status (bit 0 at address 7) sets and the counter restarts. A threshold of 0 means 256.
- R8: Status bits are cleared by writing 1 to them. A set event in the same cycle wins over the clear. `irq` equals interrupt enable (bit 0 at address 6) AND (bit 0 OR bit 2 of status).
- R9: A register write to address 3 with bit 15 set clears the response write pointer and the entry counter. `rsp_in_ready` is low in that cycle. Reads of address 3 return the write pointer.
- R10: The pending count (address 8) rises by one on each command handshake and saturates at 511. It falls by one on each accepted response whose extended-word bit 4 (entry bit 36) is 0, but never below zero. Unsolicited responses leave it unchanged.
- R11: The register map is as follows:
  - 0: command write pointer, bits 7:0.
  - 1: command read pointer.
  - 2: command control, bits 1:0. Bit 0 is stored but has no effect.
  - 3: response write pointer.
  - 4: software response read pointer, bits 7:0.
  - 5: threshold, bits 7:0.
  - 6: response control, bits 1:0.
  - 7: status.
  - 8: pending count.
  - Other addresses read zero. Writes land on the rising clock edge when `reg_we` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address (read and write) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| cmd_mem_we | input | 1 | Command memory write strobe |
| cmd_mem_idx | input | 8 | Command memory write index |
| cmd_mem_wdata | input | 32 | Command word (codec 31:28, direct 27, node 26:20, verb 19:8, payload 7:0) |
| rsp_mem_idx | input | 8 | Response memory read index |
| rsp_mem_rdata | output | 64 | Response entry at `rsp_mem_idx` |
| cmd_valid | output | 1 | Command offered to link |
| cmd_ready | input | 1 | Link accepts command |
| cmd_data | output | 32 | Offered command word |
| rsp_in_valid | input | 1 | Response presented by link |
| rsp_in_ready | output | 1 | Block accepts response |
| rsp_in_data | input | 64 | Incoming response entry |
| irq | output | 1 | Response interrupt |

## Verification
The command side is exercised in several ways:
- Continuous `cmd_ready` shows back-to-back issue.
- A pseudo-random `cmd_ready` shows that stalls hold the data.
- `cmd_ready` held low while the engine is disabled separates a clean stop from one that drops the in-flight command.
- A run across index 255 to 0 exposes pointer wrap errors.

The response side is fed as follows:
- Solicited and unsolicited responses are mixed under thresholds 1, 3 and 0, which tells counting errors apart from flag handling.
- A long burst fills the ring and pushes the pending count to its floor, so the full test and the overrun status are checked separately from the underflow guard.

A clocked reference model built from queues and integers predicts every output and register read, and every output and register read is compared against it on every cycle.

// File: rtl/crr_pkg.sv
package crr_pkg;
  typedef enum logic [3:0] {
    RA_CMD_WP  = 4'd0,
    RA_CMD_RP  = 4'd1,
    RA_CMD_CTL = 4'd2,
    RA_RSP_WP  = 4'd3,
    RA_RSP_RP  = 4'd4,
    RA_RSP_CNT = 4'd5,
    RA_RSP_CTL = 4'd6,
    RA_RSP_STS = 4'd7,
    RA_PEND    = 4'd8
  } reg_addr_e;

  localparam int PTR_CLR_BIT  = 15;
  localparam int RUN_BIT      = 1;
  localparam int IEN_BIT      = 0;
  localparam int STS_RSP_BIT  = 0;
  localparam int STS_OVF_BIT  = 2;
  localparam int UNSOL_BIT    = 4;
  localparam int UNSOL_POS    = 32 + UNSOL_BIT;

  typedef struct packed {
    logic [3:0]  codec;
    logic        direct;
    logic [6:0]  node;
    logic [11:0] verb;
    logic [7:0]  payload;
  } cmd_word_t;
endpackage

// File: rtl/crr_ring_mem.sv
module crr_ring_mem #(
  parameter int W  = 32,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/crr_cmd_engine.sv
module crr_cmd_engine
  import crr_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [AW-1:0] wp,
  input  logic          clr_req,
  input  logic          ready,
  output logic          valid,
  output logic [31:0]   data,
  output logic [AW-1:0] rp,
  output logic          fire,
  output logic [AW-1:0] mem_raddr,
  input  logic [31:0]   mem_rdata
);
  logic          busy_q;
  cmd_word_t     word_q;
  logic [AW-1:0] rp_q;
  logic [AW-1:0] rp_step;
  logic [AW-1:0] rp_next;
  logic          load;

  assign fire = busy_q & ready;

  always_comb begin
    rp_step   = fire ? rp_q + 1'b1 : rp_q;
    rp_next   = (clr_req && !busy_q) ? '0 : rp_step;
    mem_raddr = rp_next + 1'b1;
    load      = (!busy_q || fire) && run && (rp_next != wp);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      word_q <= '0;
      rp_q   <= '0;
    end else begin
      rp_q <= rp_next;
      if (load) begin
        busy_q <= 1'b1;
        word_q <= mem_rdata;
      end else if (fire) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign valid = busy_q;
  assign data  = word_q;
  assign rp    = rp_q;
endmodule

// File: rtl/crr_rsp_engine.sv
module crr_rsp_engine
  import crr_pkg::*;
#(
  parameter int AW = 8,
  parameter int W  = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          clr_req,
  input  logic          in_valid,
  input  logic [W-1:0]  in_data,
  input  logic [AW-1:0] sw_rp,
  input  logic [AW-1:0] thresh,
  input  logic [1:0]    sts_w1c,
  output logic          in_ready,
  output logic [AW-1:0] wp,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [W-1:0]  mem_wdata,
  output logic          sts_resp,
  output logic          sts_ovf,
  output logic          sol_acc
);
  logic [AW-1:0] wp_q;
  logic [AW-1:0] cnt_q;
  logic [AW-1:0] wp_inc;
  logic [AW-1:0] cnt_inc;
  logic          accept, full, store, drop, hit;
  logic          resp_q, ovf_q;

  always_comb begin
    in_ready = run & ~clr_req;
    accept   = in_valid & in_ready;
    wp_inc   = wp_q + 1'b1;
    cnt_inc  = cnt_q + 1'b1;
    full     = (wp_inc == sw_rp);
    store    = accept & ~full;
    drop     = accept & full;
    hit      = store & (cnt_inc == thresh);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q   <= '0;
      cnt_q  <= '0;
      resp_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (clr_req) begin
        wp_q  <= '0;
        cnt_q <= '0;
      end else if (store) begin
        wp_q  <= wp_inc;
        cnt_q <= hit ? '0 : cnt_inc;
      end
      resp_q <= (resp_q & ~sts_w1c[0]) | hit;
      ovf_q  <= (ovf_q & ~sts_w1c[1]) | drop;
    end
  end

  assign wp        = wp_q;
  assign mem_we    = store;
  assign mem_waddr = wp_inc;
  assign mem_wdata = in_data;
  assign sts_resp  = resp_q;
  assign sts_ovf   = ovf_q;
  assign sol_acc   = accept & ~in_data[UNSOL_POS];
endmodule

// File: rtl/codec_cmd_rsp_rings.sv
module codec_cmd_rsp_rings
  import crr_pkg::*;
#(
  parameter int AW     = 8,
  parameter int PEND_W = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [3:0]    reg_addr,
  input  logic [15:0]   reg_wdata,
  output logic [15:0]   reg_rdata,
  input  logic          cmd_mem_we,
  input  logic [AW-1:0] cmd_mem_idx,
  input  logic [31:0]   cmd_mem_wdata,
  input  logic [AW-1:0] rsp_mem_idx,
  output logic [63:0]   rsp_mem_rdata,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [31:0]   cmd_data,
  input  logic          rsp_in_valid,
  output logic          rsp_in_ready,
  input  logic [63:0]   rsp_in_data,
  output logic          irq
);
  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  logic [AW-1:0]     cmd_wp_q, rsp_rp_q, rsp_cnt_q;
  logic [1:0]        cmd_ctl_q, rsp_ctl_q;
  logic [PEND_W-1:0] pend_q, pend_mid, pend_nxt;
  logic              cmd_clr, rsp_clr;
  logic [1:0]        sts_w1c;
  logic              cmd_fire, sol_acc, pend_inc;
  logic [AW-1:0]     cmd_rp, cmd_raddr, rsp_wp, rsp_waddr;
  logic [31:0]       cmd_rd;
  logic              rsp_we, sts_resp, sts_ovf;
  logic [63:0]       rsp_wd;

  assign cmd_clr = reg_we && (reg_addr == RA_CMD_RP) && reg_wdata[PTR_CLR_BIT];
  assign rsp_clr = reg_we && (reg_addr == RA_RSP_WP) && reg_wdata[PTR_CLR_BIT];
  assign sts_w1c = {reg_wdata[STS_OVF_BIT], reg_wdata[STS_RSP_BIT]}
                   & {2{reg_we && (reg_addr == RA_RSP_STS)}};

  crr_ring_mem #(.W(32), .AW(AW)) u_cmd_mem (
    .clk(clk), .we(cmd_mem_we), .waddr(cmd_mem_idx), .wdata(cmd_mem_wdata),
    .raddr(cmd_raddr), .rdata(cmd_rd)
  );

  crr_ring_mem #(.W(64), .AW(AW)) u_rsp_mem (
    .clk(clk), .we(rsp_we), .waddr(rsp_waddr), .wdata(rsp_wd),
    .raddr(rsp_mem_idx), .rdata(rsp_mem_rdata)
  );

  crr_cmd_engine #(.AW(AW)) u_cmd_eng (
    .clk(clk), .rst_n(rst_n), .run(cmd_ctl_q[RUN_BIT]), .wp(cmd_wp_q),
    .clr_req(cmd_clr), .ready(cmd_ready), .valid(cmd_valid), .data(cmd_data),
    .rp(cmd_rp), .fire(cmd_fire), .mem_raddr(cmd_raddr), .mem_rdata(cmd_rd)
  );

  crr_rsp_engine #(.AW(AW), .W(64)) u_rsp_eng (
    .clk(clk), .rst_n(rst_n), .run(rsp_ctl_q[RUN_BIT]), .clr_req(rsp_clr),
    .in_valid(rsp_in_valid), .in_data(rsp_in_data), .sw_rp(rsp_rp_q),
    .thresh(rsp_cnt_q), .sts_w1c(sts_w1c), .in_ready(rsp_in_ready),
    .wp(rsp_wp), .mem_we(rsp_we), .mem_waddr(rsp_waddr), .mem_wdata(rsp_wd),
    .sts_resp(sts_resp), .sts_ovf(sts_ovf), .sol_acc(sol_acc)
  );

  always_comb begin
    pend_inc = cmd_fire && (pend_q != PEND_MAX);
    pend_mid = pend_q + PEND_W'(pend_inc);
    pend_nxt = (sol_acc && (pend_mid != '0)) ? pend_mid - 1'b1 : pend_mid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_wp_q  <= '0;
      cmd_ctl_q <= '0;
      rsp_rp_q  <= '0;
      rsp_cnt_q <= '0;
      rsp_ctl_q <= '0;
      pend_q    <= '0;
    end else begin
      pend_q <= pend_nxt;
      if (reg_we) begin
        case (reg_addr)
          RA_CMD_WP:  cmd_wp_q  <= reg_wdata[AW-1:0];
          RA_CMD_CTL: cmd_ctl_q <= reg_wdata[1:0];
          RA_RSP_RP:  rsp_rp_q  <= reg_wdata[AW-1:0];
          RA_RSP_CNT: rsp_cnt_q <= reg_wdata[AW-1:0];
          RA_RSP_CTL: rsp_ctl_q <= reg_wdata[1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr)
      RA_CMD_WP:  reg_rdata = 16'(cmd_wp_q);
      RA_CMD_RP:  reg_rdata = 16'(cmd_rp);
      RA_CMD_CTL: reg_rdata = 16'(cmd_ctl_q);
      RA_RSP_WP:  reg_rdata = 16'(rsp_wp);
      RA_RSP_RP:  reg_rdata = 16'(rsp_rp_q);
      RA_RSP_CNT: reg_rdata = 16'(rsp_cnt_q);
      RA_RSP_CTL: reg_rdata = 16'(rsp_ctl_q);
      RA_RSP_STS: reg_rdata = {13'd0, sts_ovf, 1'b0, sts_resp};
      RA_PEND:    reg_rdata = 16'(pend_q);
      default:    reg_rdata = '0;
    endcase
  end

  assign irq = rsp_ctl_q[IEN_BIT] & (sts_resp | sts_ovf);
endmodule

// File: rtl/crr_checker.sv
module crr_checker #(
  parameter int AW = 8,
  parameter int PW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [31:0]   cmd_data,
  input logic [AW-1:0] cmd_rp,
  input logic          rsp_in_valid,
  input logic          rsp_in_ready,
  input logic [63:0]   rsp_in_data,
  input logic [AW-1:0] rsp_wp,
  input logic [AW-1:0] rsp_sw_rp,
  input logic          rsp_run,
  input logic          sts_ovf,
  input logic [PW-1:0] pend
);
  // R3
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_data));

  // R2
  rp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> cmd_rp == AW'($past(cmd_rp) + 1'b1));

  // R5
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_run |-> !rsp_in_ready);

  // R6
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_in_valid && rsp_in_ready && (AW'(rsp_wp + 1'b1) == rsp_sw_rp)
    |=> $stable(rsp_wp) && sts_ovf);

  // R10
  unsol_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_in_valid && rsp_in_ready && rsp_in_data[36] && !(cmd_valid && cmd_ready)
    |=> $stable(pend));
endmodule

bind codec_cmd_rsp_rings crr_checker #(.AW(AW), .PW(PEND_W)) u_crr_checker (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_data(cmd_data), .cmd_rp(cmd_rp), .rsp_in_valid(rsp_in_valid),
  .rsp_in_ready(rsp_in_ready), .rsp_in_data(rsp_in_data), .rsp_wp(rsp_wp),
  .rsp_sw_rp(rsp_rp_q), .rsp_run(rsp_ctl_q[1]), .sts_ovf(sts_ovf), .pend(pend_q)
);

// File: tb/test_codec_cmd_rsp_rings.sv
module test_codec_cmd_rsp_rings;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_we = 0;
  logic [3:0]  reg_addr = 0;
  logic [15:0] reg_wdata = 0;
  logic [15:0] reg_rdata;
  logic        cmd_mem_we = 0;
  logic [7:0]  cmd_mem_idx = 0;
  logic [31:0] cmd_mem_wdata = 0;
  logic [7:0]  rsp_mem_idx = 0;
  logic [63:0] rsp_mem_rdata;
  logic        cmd_valid;
  logic        cmd_ready = 0;
  logic [31:0] cmd_data;
  logic        rsp_in_valid = 0;
  logic        rsp_in_ready;
  logic [63:0] rsp_in_data = 0;
  logic        irq;

  codec_cmd_rsp_rings i_codec_cmd_rsp_rings (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_mem_we(cmd_mem_we),
    .cmd_mem_idx(cmd_mem_idx), .cmd_mem_wdata(cmd_mem_wdata),
    .rsp_mem_idx(rsp_mem_idx), .rsp_mem_rdata(rsp_mem_rdata),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .rsp_in_valid(rsp_in_valid), .rsp_in_ready(rsp_in_ready),
    .rsp_in_data(rsp_in_data), .irq(irq)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0, mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  // reference model state
  logic [31:0] m_cmem [256];
  logic [63:0] m_rmem [256];
  bit          m_rv   [256];
  int m_cwp, m_rp, m_cctl, m_srp, m_thr, m_rctl, m_wp, m_cnt, m_pend;
  bit m_busy, m_s0, m_s2;
  logic [31:0] m_cdata;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [31:0] cmdw(int i);
    return {4'(i % 16), 1'(i & 1), 7'(i * 3), 12'(i * 37), 8'(i ^ 8'h5A)};
  endfunction

  function automatic logic [15:0] m_read(int a);
    case (a)
      0: return 16'(m_cwp);
      1: return 16'(m_rp);
      2: return 16'(m_cctl);
      3: return 16'(m_wp);
      4: return 16'(m_srp);
      5: return 16'(m_thr);
      6: return 16'(m_rctl);
      7: return {13'd0, m_s2, 1'b0, m_s0};
      8: return 16'(m_pend);
      default: return 16'd0;
    endcase
  endfunction

  function automatic string reg_req(int a);
    case (a)
      1: return "R4 read cmd rp";
      3: return "R9 read rsp wp";
      5: return "R7 read threshold";
      7: return "R6 read status";
      8: return "R10 read pending";
      default: return "R11 register read";
    endcase
  endfunction

  // reference model: updates at each rising edge
  always @(posedge clk) begin
    cyc++;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (!rst_n) begin
      m_cwp = 0; m_rp = 0; m_cctl = 0; m_srp = 0; m_thr = 0; m_rctl = 0;
      m_wp = 0; m_cnt = 0; m_pend = 0; m_busy = 0; m_s0 = 0; m_s2 = 0;
      m_cdata = 0;
    end else begin
      bit clr_c, clr_r, fire, rdy, acc, hit, drop;
      int nrp, p;
      clr_c = reg_we && reg_addr == 1 && reg_wdata[15];
      clr_r = reg_we && reg_addr == 3 && reg_wdata[15];
      fire  = m_busy && cmd_ready;
      nrp = fire ? (m_rp + 1) % 256 : m_rp;
      if (clr_c && !m_busy) nrp = 0;
      if ((!m_busy || fire) && m_cctl[1] && nrp != m_cwp) begin
        m_busy = 1; m_cdata = m_cmem[(nrp + 1) % 256];
      end else if (fire) m_busy = 0;
      m_rp = nrp;
      rdy = m_rctl[1] && !clr_r;
      acc = rsp_in_valid && rdy;
      hit = 0; drop = 0;
      if (clr_r) begin m_wp = 0; m_cnt = 0; end
      else if (acc) begin
        if ((m_wp + 1) % 256 == m_srp) drop = 1;
        else begin
          m_wp = (m_wp + 1) % 256;
          m_rmem[m_wp] = rsp_in_data; m_rv[m_wp] = 1;
          m_cnt = (m_cnt + 1) % 256;
          if (m_cnt == m_thr) begin hit = 1; m_cnt = 0; end
        end
      end
      m_s0 = (m_s0 && !(reg_we && reg_addr == 7 && reg_wdata[0])) || hit;
      m_s2 = (m_s2 && !(reg_we && reg_addr == 7 && reg_wdata[2])) || drop;
      p = m_pend + ((fire && m_pend != 511) ? 1 : 0);
      if (acc && !rsp_in_data[36] && p != 0) p--;
      m_pend = p;
      if (cmd_mem_we) m_cmem[cmd_mem_idx] = cmd_mem_wdata;
      if (reg_we) case (reg_addr)
        0: m_cwp  = reg_wdata[7:0];
        2: m_cctl = reg_wdata[1:0];
        4: m_srp  = reg_wdata[7:0];
        5: m_thr  = reg_wdata[7:0];
        6: m_rctl = reg_wdata[1:0];
        default: ;
      endcase
    end
    if (cyc == 150000) begin
      n_fail++;
      $display("FAIL watchdog (all R): actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit exp_rdy;
      exp_rdy = m_rctl[1] && !(reg_we && reg_addr == 3 && reg_wdata[15]);
      chk("R2 cmd_valid", 64'(cmd_valid), 64'(m_busy));
      if (m_busy) chk("R3 cmd_data", 64'(cmd_data), 64'(m_cdata));
      chk("R5 rsp_in_ready", 64'(rsp_in_ready), 64'(exp_rdy));
      chk("R8 irq", 64'(irq), 64'(m_rctl[0] && (m_s0 || m_s2)));
      chk(reg_req(int'(reg_addr)), 64'(reg_rdata), 64'(m_read(int'(reg_addr))));
      if (m_rv[rsp_mem_idx]) chk("R5 response entry", rsp_mem_rdata, m_rmem[rsp_mem_idx]);
    end
  end

  task automatic step();
    @(posedge clk); #1;
    reg_we = 0; cmd_mem_we = 0; rsp_in_valid = 0;
    reg_addr = 4'(cyc % 9); rsp_mem_idx = 8'(cyc * 7);
    cmd_ready = (mode == 0) ? 1'b1 : (mode == 1) ? lfsr[0] : 1'b0;
  endtask

  task automatic wreg(int a, logic [15:0] d);
    step(); reg_we = 1; reg_addr = 4'(a); reg_wdata = d;
  endtask

  task automatic wcmd(int i);
    step(); cmd_mem_we = 1; cmd_mem_idx = 8'(i); cmd_mem_wdata = cmdw(i);
  endtask

  task automatic rsp(int i, bit unsol);
    step(); rsp_in_valid = 1;
    rsp_in_data = {27'(i * 11), unsol, 4'(i), 32'hC0DE_0000 + 32'(i)};
  endtask

  task automatic idle(int n);
    repeat (n) step();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    step(); #1;
    // R1 reset state
    chk("R1 cmd_valid after reset", 64'(cmd_valid), 64'd0);
    chk("R1 rsp_in_ready after reset", 64'(rsp_in_ready), 64'd0);
    chk("R1 irq after reset", 64'(irq), 64'd0);
    idle(10);
    // R2 back-to-back issue, then stalls
    for (int i = 1; i <= 9; i++) wcmd(i);
    wreg(2, 16'h0002); wreg(0, 16'd4); idle(10);
    mode = 1; wreg(0, 16'd6); idle(25);
    // R3 disable with a command in flight
    mode = 2; wreg(0, 16'd9); idle(3); wreg(2, 16'h0001); idle(3);
    mode = 0; idle(6);
    // R4 clear while idle, write without bit 15, clear while busy
    wreg(1, 16'h8000); idle(2); wreg(1, 16'h0005); idle(2);
    wreg(0, 16'd3); mode = 2; wreg(2, 16'h0002); idle(2);
    wreg(1, 16'h8000); idle(2); mode = 0; idle(8);
    // R2 wrap across 255 -> 0
    for (int i = 0; i < 256; i++) wcmd(i);
    wreg(0, 16'd255); idle(280); wreg(0, 16'd2); idle(10);
    // R5 R7 R8 responses with threshold 1
    wreg(5, 16'd1); wreg(6, 16'h0003);
    rsp(1, 0); rsp(2, 0); idle(2); wreg(7, 16'h0001); idle(2);
    rsp(3, 1); rsp(4, 0); idle(2); wreg(7, 16'h0005);
    // R7 threshold 3, mixed
    wreg(5, 16'd3);
    for (int i = 5; i < 12; i++) begin rsp(i, i[0]); idle(1); end
    wreg(7, 16'h0001); idle(2);
    // R5 disabled engine ignores input, R8 irq gated by enable
    wreg(6, 16'h0001); rsp(50, 0); idle(2); wreg(6, 16'h0002); rsp(51, 0); idle(2);
    wreg(6, 16'h0003);
    // R6 overrun, R10 pending floor, threshold 0 means 256
    wreg(5, 16'd0); wreg(4, 16'd0);
    for (int i = 0; i < 300; i++) rsp(100 + i, 0);
    idle(3); wreg(7, 16'h0004); idle(2);
    wreg(4, 16'd200); rsp(7, 0); rsp(8, 1); idle(3);
    // R9 clear write pointer, then store again
    wreg(3, 16'h0004); idle(1); wreg(3, 16'h8000); rsp(9, 0); rsp(10, 0); idle(4);
    wreg(7, 16'h0005); idle(4);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule